// File: doc/BRIEF.md
# Prescaled SPI Master

This block is the master end of an SPI link. It derives the serial clock from the system clock with a power-of-two divider. A 3-bit rate field picks the divider. Each frame is shifted out on MOSI while MISO is captured. The frame is 8 or 16 bits wide and goes MSB-first or LSB-first. Clock polarity and phase may take any of their four combinations. All of these settings are read at run time and frozen at the start of each frame.

The host sees one transmit buffer and one receive buffer. A host write fills the transmit buffer. The engine takes the word as soon as it is idle and the slave-select input is high. TXE then shows that the buffer can be written again. When a frame finishes, the received word moves to the receive buffer and RXNE is raised. A host read strobe clears RXNE. A busy flag covers the whole frame on the wire.

Top module: `spi_prescaled_master`

## Requirements
- R1: While busy, SCK holds each level for exactly 2^BR system clocks, where BR is the 3-bit rate field. The full SCK period is therefore 2^(BR+1) clocks, from 2 to 256.
- R2: While not busy, SCK equals the live `cfg_cpol` input. It is low for 0 and high for 1.
- R3: With CPHA=0, MISO is sampled on the odd (leading) SCK edges and MOSI moves to the next bit on the even edges. With CPHA=1, MISO is sampled on the even edges, and MOSI moves on the odd edges from the third edge on. MOSI is 0 while idle.
- R4: `cfg_wide`=0 gives an 8-bit frame using data bits 7:0, and the received word then has bits 15:8 equal to 0. `cfg_wide`=1 gives a 16-bit frame.
- R5: `cfg_lsb_first`=0 sends and receives bit N-1 first. `cfg_lsb_first`=1 sends and receives bit 0 first.
- R6: A host write sets the transmit buffer full, so TXE=0. The cycle after the buffer is full, the engine is idle and `ss_in_n` is high, the frame starts and TXE returns to 1.
- R7: While `ss_in_n` is low, no frame starts, and a full transmit buffer stays full.
- R8: `busy` rises with the frame start and stays high for exactly 2·N·2^BR clocks. It falls in the same cycle as the last SCK edge.
- R9: At frame end, `rd_data` takes the received word and RXNE is set. A `rd_en` pulse clears RXNE. Frame end wins if both happen in the same cycle.
- R10: Rate, polarity, phase, width and order are captured at frame start. Changing them mid-frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_br | input | 3 | Rate field; SCK period is 2^(cfg_br+1) clocks |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_wide | input | 1 | 0: 8-bit frame, 1: 16-bit frame |
| cfg_lsb_first | input | 1 | 0: MSB first, 1: LSB first |
| ss_in_n | input | 1 | Slave-select sense; must be high for frames to start |
| wr_en | input | 1 | Host write strobe into the transmit buffer |
| wr_data | input | 16 | Host write data |
| rd_en | input | 1 | Host read strobe, clears RXNE |
| rd_data | output | 16 | Receive buffer contents |
| txe | output | 1 | Transmit buffer empty |
| rxne | output | 1 | Receive buffer holds an unread word |
| busy | output | 1 | Frame in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench runs all four phase modes, both widths and both bit orders. It uses divide-by-2 and the slowest rate, where an off-by-one in the half-period counter would stretch or shrink every SCK level. A slave model drives MISO with a bit that changes only when the master should shift. Sampling on the wrong edge therefore returns a neighbouring bit and corrupts the received word. Back-to-back frames test that the second word waits for the true end of the first frame and that TXE reopens only at start. Mid-frame configuration changes catch a design that reads live settings rather than captured ones. A low slave-select with a loaded buffer catches a design that starts regardless.

// File: rtl/spi_pm_pkg.sv
package spi_pm_pkg;
  localparam int WORD_W   = 16;
  localparam int NARROW_W = 8;
  localparam int BR_W     = 3;
  localparam int IDX_W    = $clog2(WORD_W);
  localparam int EDGE_W   = $clog2(2 * WORD_W + 1);
  localparam int HCNT_W   = (1 << BR_W) - 1;

  typedef struct packed {
    logic [BR_W-1:0] br;
    logic            cpol;
    logic            cpha;
    logic            wide;
    logic            lsb_first;
  } spi_cfg_t;

  // System clocks per SCK level.
  function automatic int half_period(logic [BR_W-1:0] br);
    return 1 << br;
  endfunction

  function automatic int frame_bits(logic wide);
    return wide ? WORD_W : NARROW_W;
  endfunction

  // Which bit of the frame is on the wire after a number of SCK edges.
  function automatic int bit_index(int edges_done, logic cpha);
    if (!cpha) return edges_done / 2;
    if (edges_done == 0) return 0;
    return (edges_done - 1) / 2;
  endfunction

  // Position in the data word of the k-th bit on the wire.
  function automatic int wire_pos(int idx, int nbits, logic lsb_first);
    return lsb_first ? idx : nbits - 1 - idx;
  endfunction
endpackage

// File: rtl/spi_pm_prescaler.sv
module spi_pm_prescaler
  import spi_pm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [BR_W-1:0] br,
  output logic            tick
);
  logic [HCNT_W-1:0] hcnt;
  logic              at_limit;

  assign at_limit = (int'(hcnt) == half_period(br) - 1);
  assign tick     = run && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hcnt <= '0;
    else if (!run || at_limit) hcnt <= '0;
    else                       hcnt <= hcnt + 1'b1;
  end
endmodule

// File: rtl/spi_pm_engine.sv
module spi_pm_engine
  import spi_pm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  input  logic              miso,
  input  logic              idle_cpol,
  input  spi_cfg_t          cfg_in,
  input  logic [WORD_W-1:0] tx_in,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              frame_done,
  output spi_cfg_t          cfg_q,
  output logic [WORD_W-1:0] rx_word
);
  logic [EDGE_W-1:0] edge_cnt;
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_sh;
  logic [IDX_W-1:0]  cur_pos;
  logic              leading;
  logic              last_edge;
  logic              sample_edge;
  int                nbits;

  always_comb begin
    nbits       = frame_bits(cfg_q.wide);
    cur_pos     = IDX_W'(wire_pos(bit_index(int'(edge_cnt), cfg_q.cpha), nbits, cfg_q.lsb_first));
    leading     = ~edge_cnt[0];
    last_edge   = (int'(edge_cnt) == 2 * nbits - 1);
    sample_edge = busy && tick && (leading ^ cfg_q.cpha);
    frame_done  = busy && tick && last_edge;
    rx_word     = rx_sh;
    if (sample_edge) rx_word[cur_pos] = miso;
    mosi        = busy ? tx_q[cur_pos] : 1'b0;
    sck         = busy ? (cfg_q.cpol ^ edge_cnt[0]) : idle_cpol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      edge_cnt <= '0;
      cfg_q    <= '0;
      tx_q     <= '0;
      rx_sh    <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      edge_cnt <= '0;
      cfg_q    <= cfg_in;
      tx_q     <= tx_in;
      rx_sh    <= '0;
    end else if (busy && tick) begin
      edge_cnt <= edge_cnt + 1'b1;
      rx_sh    <= rx_word;
      if (last_edge) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_pm_buffers.sv
module spi_pm_buffers
  import spi_pm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              start,
  input  logic              frame_done,
  input  logic [WORD_W-1:0] rx_word,
  output logic              tx_full,
  output logic [WORD_W-1:0] tx_data,
  output logic [WORD_W-1:0] rx_data,
  output logic              rxne
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_data <= '0;
    end else if (wr_en) begin
      tx_full <= 1'b1;
      tx_data <= wr_data;
    end else if (start) begin
      tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxne    <= 1'b0;
      rx_data <= '0;
    end else if (frame_done) begin
      rxne    <= 1'b1;
      rx_data <= rx_word;
    end else if (rd_en) begin
      rxne    <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_prescaled_master.sv
module spi_prescaled_master
  import spi_pm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BR_W-1:0]   cfg_br,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_wide,
  input  logic              cfg_lsb_first,
  input  logic              ss_in_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              txe,
  output logic              rxne,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  spi_cfg_t          cfg_live;
  spi_cfg_t          cfg_q;
  logic              tick;
  logic              start;
  logic              frame_done;
  logic              tx_full;
  logic [WORD_W-1:0] tx_data;
  logic [WORD_W-1:0] rx_word;

  assign cfg_live = '{br: cfg_br, cpol: cfg_cpol, cpha: cfg_cpha,
                      wide: cfg_wide, lsb_first: cfg_lsb_first};
  assign start    = tx_full && !busy && ss_in_n;
  assign txe      = ~tx_full;

  spi_pm_prescaler u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .br    (cfg_q.br),
    .tick  (tick)
  );

  spi_pm_engine u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .tick       (tick),
    .miso       (miso),
    .idle_cpol  (cfg_cpol),
    .cfg_in     (cfg_live),
    .tx_in      (tx_data),
    .busy       (busy),
    .sck        (sck),
    .mosi       (mosi),
    .frame_done (frame_done),
    .cfg_q      (cfg_q),
    .rx_word    (rx_word)
  );

  spi_pm_buffers u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .start      (start),
    .frame_done (frame_done),
    .rx_word    (rx_word),
    .tx_full    (tx_full),
    .tx_data    (tx_data),
    .rx_data    (rd_data),
    .rxne       (rxne)
  );
endmodule

// File: rtl/spi_pm_checker.sv
module spi_pm_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic tick,
  input logic sck,
  input logic mosi,
  input logic start,
  input logic wr_en,
  input logic txe,
  input logic ss_in_n,
  input logic frame_done,
  input logic rxne,
  input logic rd_en
);
  a_r1_sck_flips_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tick && !frame_done |=> sck != $past(sck));

  a_r1_sck_holds_between: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tick |=> $stable(sck));

  a_r3_mosi_moves_on_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tick |=> $stable(mosi));

  a_r6_txe_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start && !wr_en |=> txe);

  a_r7_ss_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !ss_in_n |=> !busy);

  a_r8_busy_ends_on_last_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(frame_done));

  a_r9_rxne_set: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rxne);

  a_r9_rxne_cleared_by_read: assert property (@(posedge clk) disable iff (!rst_n)
    rxne && rd_en && !frame_done |=> !rxne);
endmodule

bind spi_prescaled_master spi_pm_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .tick       (tick),
  .sck        (sck),
  .mosi       (mosi),
  .start      (start),
  .wr_en      (wr_en),
  .txe        (txe),
  .ss_in_n    (ss_in_n),
  .frame_done (frame_done),
  .rxne       (rxne),
  .rd_en      (rd_en)
);

// File: tb/tb_spi_prescaled_master.sv
module tb_spi_prescaled_master;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_br;
  logic        cfg_cpol, cfg_cpha, cfg_wide, cfg_lsb_first;
  logic        ss_in_n, wr_en, rd_en, miso;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        txe, rxne, busy, sck, mosi;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  spi_prescaled_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_br(cfg_br), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_wide(cfg_wide), .cfg_lsb_first(cfg_lsb_first),
    .ss_in_n(ss_in_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .txe(txe), .rxne(rxne), .busy(busy), .sck(sck),
    .mosi(mosi), .miso(miso)
  );

  // The slave answers each word with a fixed scramble of it.
  function automatic logic [15:0] slave_reply(logic [15:0] w);
    return {w[7:0], w[15:8]} ^ 16'h6C39;
  endfunction

  function automatic int order_pos(int k, int n, bit lsb);
    if (lsb) return k;
    return n - 1 - k;
  endfunction

  function automatic int cur_bit(int edges, bit cpha);
    int v;
    v = (cpha ? edges + 1 : edges + 2) / 2 - 1;
    return (v < 0) ? 0 : v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: elapsed-time view of one frame.
  bit          m_txfull, m_busy, m_rxne, m_cpol, m_cpha, m_lsb;
  logic [15:0] m_txbuf, m_txword, m_rxbuf;
  int          m_el, m_h, m_n;

  always @(posedge clk) begin
    bit st;
    bit dn;
    if (!rst_n) begin
      m_txfull = 0; m_busy = 0; m_rxne = 0; m_cpol = 0; m_cpha = 0; m_lsb = 0;
      m_txbuf = '0; m_txword = '0; m_rxbuf = '0; m_el = 0; m_h = 1; m_n = 8;
    end else begin
      st = m_txfull && !m_busy && ss_in_n;
      dn = m_busy && (m_el == 2 * m_n * m_h - 1);
      if (m_busy) m_el++;
      if (dn) begin
        m_busy  = 0;
        m_rxbuf = slave_reply(m_txword) & ((m_n == 16) ? 16'hFFFF : 16'h00FF);
        m_rxne  = 1;
      end else if (rd_en) begin
        m_rxne = 0;
      end
      if (st) begin
        m_busy = 1; m_el = 0; m_txword = m_txbuf;
        m_h = 1 << cfg_br; m_n = cfg_wide ? 16 : 8;
        m_cpol = cfg_cpol; m_cpha = cfg_cpha; m_lsb = cfg_lsb_first;
      end
      if (wr_en) begin
        m_txfull = 1; m_txbuf = wr_data;
      end else if (st) begin
        m_txfull = 0;
      end
    end
  end

  // Per-cycle comparison, and the slave's MISO drive.
  always @(posedge clk) begin
    int edges;
    int pos;
    logic [15:0] reply;
    #2;
    if (rst_n) begin
      check(busy === m_busy, "R8", "busy", {15'd0, busy}, {15'd0, m_busy});
      check(txe === !m_txfull, "R6", "txe", {15'd0, txe}, {15'd0, !m_txfull});
      check(rxne === m_rxne, "R9", "rxne", {15'd0, rxne}, {15'd0, m_rxne});
      if (m_rxne) check(rd_data === m_rxbuf, "R4", "rd_data", rd_data, m_rxbuf);
      if (m_busy) begin
        edges = m_el / m_h;
        check(sck === (m_cpol ^ edges[0]), "R1", "sck", {15'd0, sck},
              {15'd0, m_cpol ^ edges[0]});
        pos = order_pos(cur_bit(edges, m_cpha), m_n, m_lsb);
        check(mosi === m_txword[pos], "R3/R5", "mosi", {15'd0, mosi},
              {15'd0, m_txword[pos]});
        reply = slave_reply(m_txword);
        miso = reply[pos];
      end else begin
        check(sck === cfg_cpol, "R2", "idle sck", {15'd0, sck}, {15'd0, cfg_cpol});
        check(mosi === 1'b0, "R3", "idle mosi", {15'd0, mosi}, 16'd0);
        miso = 1'b0;
      end
    end
  end

  task automatic set_cfg(input logic [2:0] br, input bit cp, input bit ph,
                         input bit wd, input bit lsb);
    @(negedge clk);
    cfg_br = br; cfg_cpol = cp; cfg_cpha = ph; cfg_wide = wd; cfg_lsb_first = lsb;
  endtask

  task automatic write_word(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic host_read();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_rx();
    do @(negedge clk); while (!rxne);
  endtask

  task automatic expect_rx(input logic [15:0] d, input bit wd, input string tag);
    logic [15:0] exp;
    exp = slave_reply(d) & (wd ? 16'hFFFF : 16'h00FF);
    check(rxne === 1'b1, "R9", "rxne at frame end", {15'd0, rxne}, 16'd1);
    check(rd_data === exp, tag, "received word", rd_data, exp);
    host_read();
    check(rxne === 1'b0, "R9", "rxne after read", {15'd0, rxne}, 16'd0);
  endtask

  task automatic one_frame(input logic [2:0] br, input bit cp, input bit ph,
                           input bit wd, input bit lsb, input logic [15:0] d,
                           input string tag);
    set_cfg(br, cp, ph, wd, lsb);
    write_word(d);
    wait_rx();
    expect_rx(d, wd, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_br = '0; cfg_cpol = 0; cfg_cpha = 0; cfg_wide = 0;
    cfg_lsb_first = 0; ss_in_n = 1; wr_en = 0; rd_en = 0; wr_data = '0; miso = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txe === 1'b1, "R6", "reset txe", {15'd0, txe}, 16'd1);
    check(rxne === 1'b0, "R9", "reset rxne", {15'd0, rxne}, 16'd0);
    check(busy === 1'b0, "R8", "reset busy", {15'd0, busy}, 16'd0);
    check(sck === 1'b0, "R2", "reset sck", {15'd0, sck}, 16'd0);

    // R1 R3 R4 R5 across modes, widths, orders and rates
    one_frame(3'd0, 0, 0, 0, 0, 16'h00A5, "R4/R5 mode0 8b msb");
    one_frame(3'd1, 1, 0, 1, 0, 16'h1234, "R4/R5 mode2 16b msb");
    one_frame(3'd0, 0, 1, 0, 1, 16'hFF3C, "R4/R5 mode1 8b lsb");
    one_frame(3'd2, 1, 1, 1, 1, 16'hBEEF, "R4/R5 mode3 16b lsb");
    one_frame(3'd7, 0, 0, 0, 0, 16'h0081, "R1 slowest rate");

    // R6: second word queued while the first is on the wire
    set_cfg(3'd1, 0, 1, 1, 0);
    write_word(16'hC0DE);
    do @(negedge clk); while (!txe);
    check(busy === 1'b1, "R6", "busy once buffer drained", {15'd0, busy}, 16'd1);
    write_word(16'h5A0F);
    check(txe === 1'b0, "R6", "second word held", {15'd0, txe}, 16'd0);
    wait_rx();
    expect_rx(16'hC0DE, 1, "R6 first of pair");
    wait_rx();
    expect_rx(16'h5A0F, 1, "R6 second of pair");

    // R10: settings changed mid-frame
    set_cfg(3'd1, 0, 0, 1, 0);
    write_word(16'h9176);
    do @(negedge clk); while (!busy);
    repeat (5) @(negedge clk);
    cfg_br = 3'd0; cfg_cpha = 1; cfg_wide = 0; cfg_lsb_first = 1;
    wait_rx();
    expect_rx(16'h9176, 1, "R10 captured settings");

    // R7: slave-select low holds the buffered word
    set_cfg(3'd0, 0, 0, 0, 0);
    ss_in_n = 1'b0;
    write_word(16'h0055);
    repeat (40) @(negedge clk);
    check(busy === 1'b0, "R7", "no start while ss low", {15'd0, busy}, 16'd0);
    check(txe === 1'b0, "R7", "buffer still full", {15'd0, txe}, 16'd0);
    ss_in_n = 1'b1;
    wait_rx();
    expect_rx(16'h0055, 0, "R7 released frame");

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule